// File: doc/BRIEF.md
# Keyed Power-Domain Reset Controller

This block sits in the always-on power-management domain and produces the reset lines for three other domains: the die-level logic, the application processor and a small auxiliary microcontroller. Software reaches it through a plain word-addressed register port. The port has a write strobe, an address and write data, and a read-data output that follows the address combinationally. The port accepts every write in the cycle it is presented, so it has no back-pressure and no handshake.

Two of the resets are protected against stray writes. Each has its own 16-bit unlock key, written to its own key register. The key arms exactly one later write to the control register. The microcontroller reset is a plain level that software holds and releases. A write of a magic value to a trigger register fires a whole-chip reset pulse. A separate key register gates a GPIO function: the correct key unlocks it and any other value locks it again.

All generated reset pulses have a fixed length. The controller's own state is cleared only by the external power-on reset. None of the resets it produces clears that state.

Top module: `pm_rst_ctrl`

## Requirements
- R1: After power-on reset, all reset outputs and `gpio4_unlocked` are 0, and every register reads 0.
- R2: A write of 0xB8D4 to offset 0xB4, followed by a write to offset 0xA4 with bit 11 set, drives `die_rst` high starting in the cycle after the control write. It stays high for exactly 16 cycles.
- R3: A write of 0xB8D3 to offset 0xB0, followed by a write to offset 0xA4 with bit 10 set, drives `cpu_rst` high starting in the cycle after the control write. It stays high for exactly 16 cycles.
- R4: If no key has been written, or the key register holds any other value, setting bit 11 or bit 10 at offset 0xA4 is ignored and the matching reset output stays 0.
- R5: The first write to offset 0xA4 after a key write disarms both keys, whatever value it carries. A further keyed reset needs the key to be written again.
- R6: `mcu_rst` takes the value of bit 12 from each write to offset 0xA4, one cycle after the write. It keeps that value until the next write to 0xA4.
- R7: A write of exactly 0x0079 to offset 0xB8 drives `chip_rst` high for exactly 16 cycles, starting in the cycle after the write. Any other value at 0xB8 has no effect.
- R8: A write of 0xBABE to offset 0x48 sets `gpio4_unlocked` to 1 in the next cycle. A write of any other value to 0x48 clears it.
- R9: A write to offset 0xAC changes no output and does not consume an armed key.
- R10: Reads work as follows:
  - Offset 0xA4 returns bit 12 = microcontroller level, bit 11 = die pulse active and bit 10 = processor pulse active, with all other bits 0.
  - Offset 0x48 returns the unlock state in bit 0 (1 = unlocked).
  - The key registers, the trigger register and any other offset read 0.
- R11: A chip, die or processor reset pulse leaves the microcontroller level and the GPIO unlock state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 8 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current `addr` |
| die_rst | output | 1 | Die-domain reset pulse, active high |
| cpu_rst | output | 1 | Application processor reset pulse, active high |
| mcu_rst | output | 1 | Microcontroller reset level, active high |
| chip_rst | output | 1 | Whole-chip reset pulse, active high |
| gpio4_unlocked | output | 1 | GPIO function unlock state |

## Verification
A key flag left armed by mistake shows up at the ports only when software next sets a gated bit. That next write then fires a reset pulse that should not exist, one cycle later. Keyed writes, wrong keys and consuming writes are therefore interleaved so that every armed or disarmed state is followed by a probing control write. A wrong pulse counter shows up as an edge one cycle early or late on the reset output, and as the matching active bit in the control readback. The reference model is compared against every output on every clock, so such a counter error is caught in the exact cycle where it first appears.

// File: rtl/pm_rst_pkg.sv
package pm_rst_pkg;

  localparam logic [7:0] OFS_GPIO_LOCK = 8'h48;
  localparam logic [7:0] OFS_CTRL      = 8'hA4;
  localparam logic [7:0] OFS_KEY_CPU   = 8'hB0;
  localparam logic [7:0] OFS_KEY_DIE   = 8'hB4;
  localparam logic [7:0] OFS_CHIP_TRIG = 8'hB8;

  localparam logic [15:0] KEY_DIE    = 16'hB8D4;
  localparam logic [15:0] KEY_CPU    = 16'hB8D3;
  localparam logic [15:0] CHIP_MAGIC = 16'h0079;
  localparam logic [15:0] GPIO_KEY   = 16'hBABE;

  localparam int BIT_CPU = 10;
  localparam int BIT_DIE = 11;
  localparam int BIT_MCU = 12;

  // gated channels: 0 = die domain, 1 = application processor
  localparam int N_GATED = 2;

  function automatic logic [7:0] gate_ofs(input int idx);
    return (idx == 0) ? OFS_KEY_DIE : OFS_KEY_CPU;
  endfunction

  function automatic logic [15:0] gate_key(input int idx);
    return (idx == 0) ? KEY_DIE : KEY_CPU;
  endfunction

  function automatic int gate_bit(input int idx);
    return (idx == 0) ? BIT_DIE : BIT_CPU;
  endfunction

endpackage

// File: rtl/pm_key_latch.sv
module pm_key_latch #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              consume,
  output logic              armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (key_wr) begin
      armed <= (wdata == KEY);
    end else if (consume) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_pulse_gen.sv
module pm_pulse_gen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/pm_rst_ctrl.sv
module pm_rst_ctrl
  import pm_rst_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              die_rst,
  output logic              cpu_rst,
  output logic              mcu_rst,
  output logic              chip_rst,
  output logic              gpio4_unlocked
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CHIP = ADDR_W'(OFS_CHIP_TRIG);
  localparam logic [ADDR_W-1:0] A_GPIO = ADDR_W'(OFS_GPIO_LOCK);

  logic wr_ctrl, wr_chip, wr_gpio;
  logic [N_GATED-1:0] key_armed;
  logic [N_GATED-1:0] gate_fire;
  logic [N_GATED-1:0] gate_act;
  logic mcu_q;
  logic chip_fire;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_chip = wr_en && (addr == A_CHIP);
  assign wr_gpio = wr_en && (addr == A_GPIO);

  for (genvar g = 0; g < N_GATED; g++) begin : g_gate
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(gate_ofs(g));
    localparam logic [DATA_W-1:0] KEYV  = DATA_W'(gate_key(g));
    localparam int                BITP  = gate_bit(g);

    pm_key_latch #(.DATA_W(DATA_W), .KEY(KEYV)) u_key (
      .clk    (clk),
      .rst_n  (por_n),
      .key_wr (wr_en && (addr == A_KEY)),
      .wdata  (wdata),
      .consume(wr_ctrl),
      .armed  (key_armed[g])
    );

    assign gate_fire[g] = wr_ctrl && wdata[BITP] && key_armed[g];

    pm_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst_n (por_n),
      .fire  (gate_fire[g]),
      .active(gate_act[g])
    );
  end

  assign die_rst = gate_act[0];
  assign cpu_rst = gate_act[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mcu_q <= 1'b0;
    end else if (wr_ctrl) begin
      mcu_q <= wdata[BIT_MCU];
    end
  end
  assign mcu_rst = mcu_q;

  assign chip_fire = wr_chip && (wdata == DATA_W'(CHIP_MAGIC));

  pm_pulse_gen #(.LEN(PULSE_LEN)) u_chip_pulse (
    .clk   (clk),
    .rst_n (por_n),
    .fire  (chip_fire),
    .active(chip_rst)
  );

  pm_key_latch #(.DATA_W(DATA_W), .KEY(DATA_W'(GPIO_KEY))) u_gpio_key (
    .clk    (clk),
    .rst_n  (por_n),
    .key_wr (wr_gpio),
    .wdata  (wdata),
    .consume(1'b0),
    .armed  (gpio4_unlocked)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[BIT_MCU] = mcu_q;
      rdata[BIT_DIE] = gate_act[0];
      rdata[BIT_CPU] = gate_act[1];
    end else if (addr == A_GPIO) begin
      rdata[0] = gpio4_unlocked;
    end
  end

endmodule

// File: rtl/pm_rst_ctrl_chk.sv
module pm_rst_ctrl_chk
  import pm_rst_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              die_rst,
  input logic              cpu_rst,
  input logic              mcu_rst,
  input logic              chip_rst,
  input logic              gpio4_unlocked
);

  logic [31:0] die_len, chip_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      die_len  <= '0;
      chip_len <= '0;
    end else begin
      die_len  <= die_rst  ? die_len + 1  : '0;
      chip_len <= chip_rst ? chip_len + 1 : '0;
    end
  end

  p_die_from_ctrl_write_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(die_rst) |-> $past(wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[BIT_DIE]));

  p_die_len_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(die_rst) |-> die_len >= PULSE_LEN);

  p_cpu_from_ctrl_write_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_rst) |-> $past(wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[BIT_CPU]));

  p_mcu_follows_bit_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(OFS_CTRL)) |=> (mcu_rst == $past(wdata[BIT_MCU])));

  p_chip_needs_magic_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(chip_rst) |-> $past(wr_en && addr == ADDR_W'(OFS_CHIP_TRIG) && wdata == DATA_W'(CHIP_MAGIC)));

  p_chip_len_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst) |-> chip_len >= PULSE_LEN);

  p_gpio_key_r8: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(OFS_GPIO_LOCK)) |=> (gpio4_unlocked == ($past(wdata) == DATA_W'(GPIO_KEY))));

  p_ac_inert_r9: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(8'hAC)) |=> ($stable(mcu_rst) && $stable(gpio4_unlocked) && !$rose(die_rst) && !$rose(cpu_rst)));

  p_key_reads_zero_r10: assert property (@(posedge clk) disable iff (!por_n)
    (addr == ADDR_W'(OFS_KEY_DIE) || addr == ADDR_W'(OFS_KEY_CPU)) |-> (rdata == '0));

endmodule

bind pm_rst_ctrl pm_rst_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .die_rst(die_rst), .cpu_rst(cpu_rst), .mcu_rst(mcu_rst),
  .chip_rst(chip_rst), .gpio4_unlocked(gpio4_unlocked)
);

// File: tb/sim_pm_rst_ctrl.sv
`timescale 1ns/1ps
module sim_pm_rst_ctrl;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        die_rst, cpu_rst, mcu_rst, chip_rst, gpio4_unlocked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  int m_die = 0, m_cpu = 0, m_chip = 0;
  bit m_mcu = 0, m_unl = 0, m_kdie = 0, m_kcpu = 0;

  always #4 clk = ~clk;  // 125 MHz

  pm_rst_ctrl u0 (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .die_rst(die_rst), .cpu_rst(cpu_rst), .mcu_rst(mcu_rst),
    .chip_rst(chip_rst), .gpio4_unlocked(gpio4_unlocked)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_rdata(input logic [7:0] a);
    logic [15:0] r = 16'h0;
    if (a == 8'hA4) begin
      r[12] = m_mcu; r[11] = (m_die != 0); r[10] = (m_cpu != 0);
    end else if (a == 8'h48) begin
      r[0] = m_unl;
    end
    return r;
  endfunction

  // model step on every rising edge
  always @(posedge clk) begin
    if (!por_n) begin
      m_die = 0; m_cpu = 0; m_chip = 0;
      m_mcu = 0; m_unl = 0; m_kdie = 0; m_kcpu = 0;
    end else begin
      if (m_die  > 0) m_die--;
      if (m_cpu  > 0) m_cpu--;
      if (m_chip > 0) m_chip--;
      if (wr_en) begin
        case (addr)
          8'hB4: m_kdie = (wdata == 16'hB8D4);
          8'hB0: m_kcpu = (wdata == 16'hB8D3);
          8'hB8: if (wdata == 16'h0079) m_chip = 16;
          8'h48: m_unl = (wdata == 16'hBABE);
          8'hA4: begin
            if (wdata[11] && m_kdie) m_die = 16;
            if (wdata[10] && m_kcpu) m_cpu = 16;
            m_mcu = wdata[12];
            m_kdie = 0; m_kcpu = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (por_n && !done) begin
      chk("R2 die_rst", 16'(die_rst), 16'(m_die != 0));
      chk("R3 cpu_rst", 16'(cpu_rst), 16'(m_cpu != 0));
      chk("R6 mcu_rst", 16'(mcu_rst), 16'(m_mcu));
      chk("R7 chip_rst", 16'(chip_rst), 16'(m_chip != 0));
      chk("R8 gpio4_unlocked", 16'(gpio4_unlocked), 16'(m_unl));
      chk("R10 rdata", rdata, m_rdata(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 outputs", {11'h0, die_rst, cpu_rst, mcu_rst, chip_rst, gpio4_unlocked}, 16'h0);
    addr = 8'hA4; #1; chk("R1 read ctrl", rdata, 16'h0);
    addr = 8'h48; #1; chk("R1 read lock", rdata, 16'h0);
    @(negedge clk); por_n = 1'b1;
    idle(2);

    // R2: keyed die reset, exact length
    wr(8'hB4, 16'hB8D4);
    wr(8'hA4, 16'h0800);
    chk("R2 first cycle", 16'(die_rst), 16'h1);
    chk("R10 ctrl active bit", rdata, 16'h0800);
    idle(15); chk("R2 last cycle", 16'(die_rst), 16'h1);
    idle(1);  chk("R2 released", 16'(die_rst), 16'h0);

    // R3: keyed processor reset
    wr(8'hB0, 16'hB8D3);
    wr(8'hA4, 16'h0400);
    chk("R3 first cycle", 16'(cpu_rst), 16'h1);
    idle(15); chk("R3 last cycle", 16'(cpu_rst), 16'h1);
    idle(1);  chk("R3 released", 16'(cpu_rst), 16'h0);

    // R4: wrong key and no key
    wr(8'hB4, 16'h1234);
    wr(8'hA4, 16'h0800);
    idle(2); chk("R4 wrong key", 16'(die_rst), 16'h0);
    wr(8'hB0, 16'hB8D4);
    wr(8'hA4, 16'h0C00);
    idle(2); chk("R4 crossed key", {14'h0, die_rst, cpu_rst}, 16'h0);

    // R5: key consumed by any control write
    wr(8'hB4, 16'hB8D4);
    wr(8'hA4, 16'h0000);
    wr(8'hA4, 16'h0800);
    idle(2); chk("R5 consumed", 16'(die_rst), 16'h0);
    wr(8'hB4, 16'hB8D4);
    wr(8'hA4, 16'h0800);
    chk("R5 rekeyed", 16'(die_rst), 16'h1);
    idle(20);

    // R6: microcontroller level
    wr(8'hA4, 16'h1000);
    chk("R6 held", 16'(mcu_rst), 16'h1);
    idle(5); chk("R6 still held", 16'(mcu_rst), 16'h1);
    wr(8'hA4, 16'h0000);
    chk("R6 released", 16'(mcu_rst), 16'h0);

    // R7: chip trigger
    wr(8'hB8, 16'h0078);
    idle(1); chk("R7 wrong value", 16'(chip_rst), 16'h0);
    wr(8'hB8, 16'h0079);
    chk("R7 fired", 16'(chip_rst), 16'h1);
    idle(15); chk("R7 last cycle", 16'(chip_rst), 16'h1);
    idle(1);  chk("R7 released", 16'(chip_rst), 16'h0);

    // R8: gpio unlock
    wr(8'h48, 16'hBABE);
    chk("R8 unlocked", 16'(gpio4_unlocked), 16'h1);
    chk("R10 lock read", rdata, 16'h0001);
    wr(8'h48, 16'hBABF);
    chk("R8 relocked", 16'(gpio4_unlocked), 16'h0);

    // R9: 0xAC inert, key survives
    wr(8'hA4, 16'h1000);
    wr(8'hB4, 16'hB8D4);
    wr(8'hAC, 16'hFFFF);
    wr(8'hAC, 16'h0000);
    chk("R9 outputs", {13'h0, die_rst, cpu_rst, mcu_rst}, 16'h0001);
    wr(8'hA4, 16'h1800);
    chk("R9 key kept", 16'(die_rst), 16'h1);
    idle(20);

    // R11: generated resets leave state alone
    wr(8'h48, 16'hBABE);
    wr(8'hB8, 16'h0079);
    idle(20);
    chk("R11 mcu kept", 16'(mcu_rst), 16'h1);
    chk("R11 unlock kept", 16'(gpio4_unlocked), 16'h1);

    // R10: write-only registers read zero
    wr(8'hB4, 16'hB8D4); chk("R10 die key read", rdata, 16'h0);
    wr(8'hB0, 16'hB8D3); chk("R10 cpu key read", rdata, 16'h0);
    wr(8'hB8, 16'h0000); chk("R10 trigger read", rdata, 16'h0);
    wr(8'hAC, 16'h829F); chk("R10 inert read", rdata, 16'h0);
    wr(8'hA4, 16'h0000);
    idle(20);

    finish_run();
  end

endmodule